// File: doc/BRIEF.md
# Two-Point Calibrated Voltage Converter

This block turns a 12-bit raw conversion code into a voltage in millivolts. Each measurement range (large and small) is described by a straight line through two calibration points. The voltage coordinates of those points are fixed. Their code coordinates are rebuilt from a pair of trimming bytes that are loaded once at start-up. The converter interpolates along the line for the selected range and forces negative results to zero. For most channels it then removes the gain of an input divider chosen by a 2-bit scale code, using a division that rounds to the nearest integer.

A conversion is started by presenting a code, a channel number and a scale code together with `inValid` while `inReady` is high. The datapath runs a shared serial divider once for the interpolation and, on divided channels, once more for the ratio. It then pulses `outValid` for one cycle. The result and its error flag stay on the outputs until the next result replaces them. Inputs that arrive while the block is busy are discarded.

Top module: `twopt_volt_conv`

## Requirements
- R1: A calibrated code point is (byte + nominal − 128) × 4, computed with signed arithmetic. The low byte [7:0] of a range's calibration word gives A0, the code paired with the higher voltage point V0. The high byte [15:8] gives A1, paired with V1. The default nominal codes are 856/733 for the large range and 833/80 for the small range.
- R2: The line result is (V0 − V1) × (raw − A1) / (A0 − A1) + V1, with the division truncated toward zero. The large range uses V0 = 4200 mV and V1 = 3600 mV. The small range uses V0 = 1000 mV and V1 = 100 mV.
- R3: A negative line result is replaced by 0.
- R4: Channel 5 returns the clamped large-range result unchanged, and channel 1 returns the clamped small-range result unchanged. On these two channels the scale code has no effect.
- R5: Every other channel computes (small × D + N/2) / N, where N/D is picked by the scale code. The ratios are 1/1 for code 0, 1000/1955 for code 1, 1000/2586 for code 2 and 100/406 for code 3.
- R6: When A0 equals A1, the result is 0 and `calErr` is high. The next result clears `calErr` when its own points differ.
- R7: Each accepted input produces exactly one single-cycle `outValid` pulse. `outMv` and `calErr` hold their values between pulses.
- R8: `inReady` is high only while the block is idle. An `inValid` presented while `inReady` is low is discarded and produces no result.
- R9: After reset, `inReady` is 1, `outValid` is 0, `outMv` is 0 and `calErr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe for a conversion |
| inReady | output | 1 | High while a request can be accepted |
| rawCode | input | 12 | Raw conversion code |
| chanSel | input | 5 | Channel number |
| scaleSel | input | 2 | Scale code choosing the divider ratio |
| bigCalib | input | 16 | Large-range trimming bytes (A1 byte high, A0 byte low) |
| smallCalib | input | 16 | Small-range trimming bytes (A1 byte high, A0 byte low) |
| outValid | output | 1 | One-cycle result strobe |
| outMv | output | 36 | Result in millivolts |
| calErr | output | 1 | Result came from coincident calibration points |

## Verification
The properties assume that `inValid` is only a request and that a result is written only by one of the three completion strobes. They further assume that the calibration words do not change between a request and its result, since only the selected range's word is captured. The stimulus loads calibration words before each request and holds them until `outValid`. It sends the one deliberate collision, a request presented while `inReady` is low, one cycle after an accepted request, so the block is still in its preparation step when the collision arrives.

// File: rtl/twopt_pkg.sv
package twopt_pkg;

  localparam int BIG_CH   = 5;
  localparam int SMALL_CH = 1;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PREP,
    S_LINE,
    S_RATIO
  } conv_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic lineGo;
    logic ratioGo;
    logic errOut;
    logic lineOut;
    logic ratioOut;
  } conv_ctl_t;

  // divider ratio: numerator [31:16], denominator [15:0]
  function automatic logic [31:0] ratio_word(input logic [1:0] scale);
    case (scale)
      2'd1:    ratio_word = {16'd1000, 16'd1955};
      2'd2:    ratio_word = {16'd1000, 16'd2586};
      2'd3:    ratio_word = {16'd100,  16'd406};
      default: ratio_word = {16'd1,    16'd1};
    endcase
  endfunction

endpackage

// File: rtl/twopt_divider.sv
module twopt_divider #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  remR;
  logic [W-1:0]  denR;
  logic [CW-1:0] cnt;
  logic [W:0]    remSh;
  logic [W:0]    trial;

  assign remSh = {remR, quotient[W-1]};
  assign trial = remSh - {1'b0, denR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR     <= '0;
      denR     <= '0;
      quotient <= '0;
      cnt      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remR     <= '0;
        denR     <= divisor;
        quotient <= dividend;
        cnt      <= CW'(W);
      end else if (cnt != '0) begin
        if (!trial[W]) begin
          remR     <= trial[W-1:0];
          quotient <= {quotient[W-2:0], 1'b1};
        end else begin
          remR     <= remSh[W-1:0];
          quotient <= {quotient[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twopt_ctrl.sv
module twopt_ctrl
  import twopt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      denZero,
  input  logic      bypass,
  input  logic      divDone,
  output logic      inReady,
  output conv_ctl_t ctl
);
  conv_state_t state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (inValid) begin
        ctl.capture = 1'b1;
        nextState   = S_PREP;
      end
      S_PREP: if (denZero) begin
        ctl.errOut = 1'b1;
        nextState  = S_IDLE;
      end else begin
        ctl.lineGo = 1'b1;
        nextState  = S_LINE;
      end
      S_LINE: if (divDone) begin
        if (bypass) begin
          ctl.lineOut = 1'b1;
          nextState   = S_IDLE;
        end else begin
          ctl.ratioGo = 1'b1;
          nextState   = S_RATIO;
        end
      end
      S_RATIO: if (divDone) begin
        ctl.ratioOut = 1'b1;
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign inReady = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/twopt_datapath.sv
module twopt_datapath
  import twopt_pkg::*;
#(
  parameter int RAW_W     = 12,
  parameter int CH_W      = 5,
  parameter int OUT_W     = 36,
  parameter int DIV_W     = 48,
  parameter int BIG_NOM0  = 856,
  parameter int BIG_NOM1  = 733,
  parameter int SML_NOM0  = 833,
  parameter int SML_NOM1  = 80,
  parameter int BIG_V0    = 4200,
  parameter int BIG_V1    = 3600,
  parameter int SML_V0    = 1000,
  parameter int SML_V1    = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  conv_ctl_t        ctl,
  input  logic [RAW_W-1:0] rawCode,
  input  logic [CH_W-1:0]  chanSel,
  input  logic [1:0]       scaleSel,
  input  logic [15:0]      bigCalib,
  input  logic [15:0]      smallCalib,
  output logic             denZero,
  output logic             bypass,
  output logic             divDone,
  output logic             outValid,
  output logic [OUT_W-1:0] outMv,
  output logic             calErr
);
  localparam int ACC_W = DIV_W;

  logic [RAW_W-1:0] rawQ;
  logic [CH_W-1:0]  chanQ;
  logic [1:0]       scaleQ;
  logic             bigQ;
  logic [15:0]      calQ;
  logic             negQR;

  logic signed [ACC_W-1:0] pt0, pt1, den, num, diffV, baseV, rawS;
  logic signed [ACC_W-1:0] qS, lineVal, voltC;
  logic [ACC_W-1:0] absNum, absDen, voltU, ratDividend;
  logic [31:0]      rWord;
  logic [15:0]      rNum, rDen;
  logic             divStart;
  logic [ACC_W-1:0] divA, divB, divQuo;

  // captured request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ   <= '0;
      chanQ  <= '0;
      scaleQ <= '0;
      bigQ   <= 1'b0;
      calQ   <= '0;
    end else if (ctl.capture) begin
      rawQ   <= rawCode;
      chanQ  <= chanSel;
      scaleQ <= scaleSel;
      bigQ   <= (chanSel == CH_W'(BIG_CH));
      calQ   <= (chanSel == CH_W'(BIG_CH)) ? bigCalib : smallCalib;
    end
  end

  // calibration points and line terms
  always_comb begin
    pt0   = ($signed({{(ACC_W-8){1'b0}}, calQ[7:0]})
             + ACC_W'(bigQ ? BIG_NOM0 : SML_NOM0) - ACC_W'(128)) * ACC_W'(4);
    pt1   = ($signed({{(ACC_W-8){1'b0}}, calQ[15:8]})
             + ACC_W'(bigQ ? BIG_NOM1 : SML_NOM1) - ACC_W'(128)) * ACC_W'(4);
    diffV = bigQ ? ACC_W'(BIG_V0 - BIG_V1) : ACC_W'(SML_V0 - SML_V1);
    baseV = bigQ ? ACC_W'(BIG_V1) : ACC_W'(SML_V1);
    rawS  = $signed({{(ACC_W-RAW_W){1'b0}}, rawQ});
    num   = diffV * (rawS - pt1);
    den   = pt0 - pt1;
    absNum = num[ACC_W-1] ? -num : num;
    absDen = den[ACC_W-1] ? -den : den;
  end

  assign denZero = (den == '0);
  assign bypass  = (chanQ == CH_W'(BIG_CH)) || (chanQ == CH_W'(SMALL_CH));

  always_ff @(posedge clk) begin
    if (!rstN)            negQR <= 1'b0;
    else if (ctl.lineGo)  negQR <= num[ACC_W-1] ^ den[ACC_W-1];
  end

  // signed quotient, offset, clamp
  always_comb begin
    qS      = $signed(divQuo);
    lineVal = (negQR ? -qS : qS) + baseV;
    voltC   = lineVal[ACC_W-1] ? '0 : lineVal;
    voltU   = voltC;
  end

  // ratio removal terms
  assign rWord       = ratio_word(scaleQ);
  assign rNum        = rWord[31:16];
  assign rDen        = rWord[15:0];
  assign ratDividend = voltU * ACC_W'(rDen) + ACC_W'(rNum >> 1);

  assign divStart = ctl.lineGo | ctl.ratioGo;
  assign divA     = ctl.lineGo ? absNum : ratDividend;
  assign divB     = ctl.lineGo ? absDen : ACC_W'(rNum);

  twopt_divider #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (divStart),
    .dividend (divA),
    .divisor  (divB),
    .done     (divDone),
    .quotient (divQuo)
  );

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outMv    <= '0;
      calErr   <= 1'b0;
    end else begin
      outValid <= ctl.errOut | ctl.lineOut | ctl.ratioOut;
      if (ctl.errOut) begin
        outMv  <= '0;
        calErr <= 1'b1;
      end else if (ctl.lineOut) begin
        outMv  <= voltU[OUT_W-1:0];
        calErr <= 1'b0;
      end else if (ctl.ratioOut) begin
        outMv  <= divQuo[OUT_W-1:0];
        calErr <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twopt_volt_conv.sv
module twopt_volt_conv
  import twopt_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int CH_W  = 5,
  parameter int OUT_W = 36,
  parameter int DIV_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [RAW_W-1:0] rawCode,
  input  logic [CH_W-1:0]  chanSel,
  input  logic [1:0]       scaleSel,
  input  logic [15:0]      bigCalib,
  input  logic [15:0]      smallCalib,
  output logic             outValid,
  output logic [OUT_W-1:0] outMv,
  output logic             calErr
);
  conv_ctl_t ctl;
  logic denZero, bypass, divDone;

  twopt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .denZero (denZero),
    .bypass  (bypass),
    .divDone (divDone),
    .inReady (inReady),
    .ctl     (ctl)
  );

  twopt_datapath #(
    .RAW_W (RAW_W),
    .CH_W  (CH_W),
    .OUT_W (OUT_W),
    .DIV_W (DIV_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .rawCode    (rawCode),
    .chanSel    (chanSel),
    .scaleSel   (scaleSel),
    .bigCalib   (bigCalib),
    .smallCalib (smallCalib),
    .denZero    (denZero),
    .bypass     (bypass),
    .divDone    (divDone),
    .outValid   (outValid),
    .outMv      (outMv),
    .calErr     (calErr)
  );
endmodule

// File: rtl/twopt_volt_conv_chk.sv
module twopt_volt_conv_chk
  import twopt_pkg::*;
#(
  parameter int OUT_W = 36
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic [OUT_W-1:0] outMv,
  input logic             calErr,
  input conv_ctl_t        ctl
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl)); // R7

  AST_PULSE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R7

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outMv) && $stable(calErr))); // R7

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    calErr |-> (outMv == '0)); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R8

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady); // R8
endmodule

bind twopt_volt_conv twopt_volt_conv_chk #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outMv    (outMv),
  .calErr   (calErr),
  .ctl      (ctl)
);

// File: tb/twopt_volt_conv_tb.sv
module twopt_volt_conv_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [11:0] rawCode = '0;
  logic [4:0]  chanSel = '0;
  logic [1:0]  scaleSel = '0;
  logic [15:0] bigCalib = 16'h8080;
  logic [15:0] smallCalib = 16'h8080;
  logic        outValid;
  logic [35:0] outMv;
  logic        calErr;

  int  nTests = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  twopt_volt_conv u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .rawCode(rawCode), .chanSel(chanSel), .scaleSel(scaleSel),
    .bigCalib(bigCalib), .smallCalib(smallCalib),
    .outValid(outValid), .outMv(outMv), .calErr(calErr)
  );

  // raw, channel, scale, large calib, small calib, expected error
  typedef struct packed {
    logic [11:0] raw;
    logic [4:0]  ch;
    logic [1:0]  sc;
    logic [15:0] bg;
    logic [15:0] sm;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{12'd2000, 5'd1,  2'd0, 16'h8080, 16'h8080, 1'b0},  // R4 small direct
    '{12'd2000, 5'd1,  2'd3, 16'h8080, 16'h8080, 1'b0},  // R4 scale ignored
    '{12'd3000, 5'd5,  2'd0, 16'h8080, 16'h8080, 1'b0},  // R4 large direct
    '{12'd3000, 5'd5,  2'd2, 16'h6090, 16'h8080, 1'b0},  // R1 R4 trimmed large
    '{12'd2000, 5'd7,  2'd0, 16'h8080, 16'h8080, 1'b0},  // R5 1/1
    '{12'd2000, 5'd7,  2'd1, 16'h8080, 16'h8080, 1'b0},  // R5 code 1
    '{12'd2000, 5'd7,  2'd2, 16'h8080, 16'h8080, 1'b0},  // R5 code 2
    '{12'd4095, 5'd12, 2'd3, 16'h8080, 16'h0010, 1'b0},  // R1 R5 code 3
    '{12'd0,    5'd1,  2'd0, 16'h8080, 16'hFF80, 1'b0},  // R3 clamp
    '{12'd5,    5'd9,  2'd2, 16'h8080, 16'hFF80, 1'b0},  // R3 clamp then ratio
    '{12'd0,    5'd5,  2'd0, 16'h7B00, 16'h8080, 1'b1},  // R6 coincident points
    '{12'd1234, 5'd20, 2'd1, 16'h8080, 16'h3040, 1'b0}   // R6 error cleared, R2
  };

  function automatic longint model(input int raw, input int ch, input int sc,
                                   input logic [15:0] bg, input logic [15:0] sm,
                                   output bit e);
    longint a0, a1, v0, v1, t, rn, rd;
    logic [15:0] w;
    bit big;
    big = (ch == 5);
    w  = big ? bg : sm;
    a0 = (longint'(w[7:0])  + (big ? 856 : 833) - 128) * 4;
    a1 = (longint'(w[15:8]) + (big ? 733 : 80)  - 128) * 4;
    v0 = big ? 4200 : 1000;
    v1 = big ? 3600 : 100;
    e  = 1'b0;
    if (a0 == a1) begin
      e = 1'b1;
      return 0;
    end
    t = (v0 - v1) * (longint'(raw) - a1) / (a0 - a1) + v1;
    if (t < 0) t = 0;
    if (ch == 5 || ch == 1) return t;
    case (sc)
      1: begin rn = 1000; rd = 1955; end
      2: begin rn = 1000; rd = 2586; end
      3: begin rn = 100;  rd = 406;  end
      default: begin rn = 1; rd = 1; end
    endcase
    return (t * rd + rn / 2) / rn;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_result(output bit ok);
    int n = 0;
    while (!outValid && n < 400) begin
      @(negedge clk);
      n++;
    end
    ok = outValid;
  endtask

  task automatic convert(input vec_t v, output longint got, output bit gotErr, output bit ok);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    rawCode = v.raw; chanSel = v.ch; scaleSel = v.sc;
    bigCalib = v.bg; smallCalib = v.sm;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    wait_result(ok);
    got = longint'(outMv);
    gotErr = calErr;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    longint got, exp, first;
    bit     gErr, eErr, ok;
    int     pulses;

    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 inReady", longint'(inReady), 1);
    check("R9 outValid", longint'(outValid), 0);
    check("R9 outMv", longint'(outMv), 0);
    check("R9 calErr", longint'(calErr), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      exp = model(int'(VECS[i].raw), int'(VECS[i].ch), int'(VECS[i].sc),
                  VECS[i].bg, VECS[i].sm, eErr);
      convert(VECS[i], got, gErr, ok);
      check($sformatf("R2 R5 result vec %0d", i), ok ? got : -1, exp);
      check($sformatf("R6 error vec %0d", i), longint'(gErr), longint'(VECS[i].err));
    end

    // R8 request while busy is dropped; R7 single pulse and hold
    @(negedge clk);
    while (!inReady) @(negedge clk);
    rawCode = 12'd2500; chanSel = 5'd1; scaleSel = 2'd0;
    bigCalib = 16'h8080; smallCalib = 16'h8080;
    inValid = 1'b1;
    @(negedge clk);
    check("R8 busy after accept", longint'(inReady), 0);
    rawCode = 12'd100; chanSel = 5'd5;
    @(negedge clk);
    inValid = 1'b0;
    rawCode = 12'd2500; chanSel = 5'd1;
    wait_result(ok);
    first = model(2500, 1, 0, 16'h8080, 16'h8080, eErr);
    check("R8 first request kept", ok ? longint'(outMv) : -1, first);
    @(negedge clk);
    check("R7 pulse one cycle", longint'(outValid), 0);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (outValid) pulses++;
    end
    check("R8 dropped request gives no result", longint'(pulses), 0);
    check("R7 result held", longint'(outMv), first);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule